// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Software Force

This block turns time-base events into two PWM output levels, `pwm_a` and `pwm_b`. A separate time-base counter supplies its count value, the zero-match and period-match strobes, the count direction and a prescaled tick enable. The block keeps one compare register per channel and raises a compare-up event when the count equals that register while the counter is counting up. Each output has its own action word. The word gives every event a 2-bit code that drives the output low, drives it high, toggles it or leaves it alone.

On top of the event actions there is a continuous software force. Software writes a shadow force word. The shadow is copied into the active force word at a selectable reload point: at counter zero, at period, at either of them, or immediately. While an output's active force field is set, the forced level replaces every event action on each tick. Typical use: program both compares and a "high at zero and period, low on compare-up" action pattern for normal polarity, or the mirror pattern for inverted polarity. The force then parks an output low while it is disabled.

Top module: `pwm_action_qual`

## Requirements
- R1: After a synchronous reset both outputs are low, both compare registers are 0, and every action field, force field and the reload mode are 00. With those values the outputs stay low while the counter runs.
- R2: Action codes: 01 drives the output low, 10 drives it high, 11 toggles it, and 00 leaves it unchanged.
- R3: Each action word (either output) places the zero event in bits 1:0, the period event in bits 3:2, the compare-A-up event in bits 5:4 and the compare-B-up event in bits 9:8. Bits 7:6 are unused.
- R4: Compare-A-up (from compare register A) and compare-B-up (from compare register B) occur on a tick where `tb_up` is 1 and `tb_count` equals the register. While `tb_up` is 0, an equal count causes no event.
- R5: When events coincide on one tick, the output takes the action of the highest-priority event whose code is not 00. The order is compare-A-up, then compare-B-up, then period, then zero.
- R6: Outputs change only at a clock edge where `tick` is 1. The new level is visible after that edge.
- R7: The active force word holds output A in bits 1:0 and output B in bits 3:2. In each field 01 forces low, 10 forces high, and 00 or 11 forces nothing. A force field that is active at a tick edge sets the output for that edge, whatever events occur.
- R8: The reload mode (`rld_wdata`) selects when the shadow force word is copied to the active word: 00 on a tick with zero match, 01 on a tick with period match, 10 on a tick with either, and 11 on every clock. In mode 11 a shadow write reaches the active word at the same edge. The copied force first acts on the tick after the copy.
- R9: In modes 00, 01 and 10, a shadow force write does not change either output before the selected reload point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled time-base tick enable |
| tb_count | input | CNT_W | Time-base counter value |
| tb_zero | input | 1 | Counter is at zero |
| tb_period | input | 1 | Counter is at period |
| tb_up | input | 1 | Counter is counting up |
| cmp_a_we | input | 1 | Write compare register A |
| cmp_b_we | input | 1 | Write compare register B |
| cmp_wdata | input | CNT_W | Compare write data |
| act_a_we | input | 1 | Write action word of output A |
| act_b_we | input | 1 | Write action word of output B |
| act_wdata | input | 10 | Action word write data |
| frc_we | input | 1 | Write shadow force word |
| frc_wdata | input | 4 | Shadow force write data |
| rld_we | input | 1 | Write force reload mode |
| rld_wdata | input | 2 | Force reload mode write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The bench builds the block with the default 16-bit count width. It drives a short period of 9 with compare values near 0, near the period and equal to each other. This makes every event coincidence, every priority pair and the compare-while-counting-down case appear within a few dozen ticks. Changing the tick divider from 1 to 3 and switching between up and up-down counting covers tick gating and direction. Each reload mode is tried with shadow writes placed away from the reload point, so that both early and on-time force changes are observable at the outputs.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int ACT_W    = 10;
    localparam int FRC_W    = 4;
    localparam int N_CH     = 2;
    localparam int OFS_ZERO = 0;
    localparam int OFS_PRD  = 2;
    localparam int OFS_CMPA = 4;
    localparam int OFS_CMPB = 8;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_IMMED  = 2'b11
    } reload_e;

    typedef struct packed {
        logic cmp_b;
        logic cmp_a;
        logic period;
        logic zero;
    } tb_events_t;

    function automatic act_e act_field(logic [ACT_W-1:0] word, int ofs);
        return act_e'(word[ofs +: 2]);
    endfunction

    function automatic logic apply_act(logic cur, act_e a);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/aq_compare.sv
module aq_compare
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    input  logic             up,
    input  logic [CNT_W-1:0] count,
    output logic             match
);

    logic [CNT_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst)     cmp_q <= '0;
        else if (we) cmp_q <= wdata;
    end

    assign match = tick & up & (count == cmp_q);

endmodule

// File: rtl/aq_force.sv
module aq_force
    import pwm_aq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [FRC_W-1:0] wdata,
    input  logic             mode_we,
    input  logic [1:0]       mode_wdata,
    input  logic             tick,
    input  logic             zero,
    input  logic             period,
    output logic [FRC_W-1:0] active
);

    logic [FRC_W-1:0] shadow_q;
    logic [FRC_W-1:0] active_q;
    reload_e          mode_q;
    logic             reload_hit;

    always_comb begin
        case (mode_q)
            RLD_ZERO:   reload_hit = tick & zero;
            RLD_PERIOD: reload_hit = tick & period;
            RLD_EITHER: reload_hit = tick & (zero | period);
            default:    reload_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            mode_q   <= RLD_ZERO;
        end else begin
            if (we)      shadow_q <= wdata;
            if (mode_we) mode_q   <= reload_e'(mode_wdata);
            if (mode_q == RLD_IMMED)
                active_q <= we ? wdata : shadow_q;
            else if (reload_hit)
                active_q <= shadow_q;
        end
    end

    assign active = active_q;

    AST_IMMED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == RLD_IMMED && we) |=> active_q == $past(wdata)); // R8

    AST_HOLD_OFF_POINT: assert property (@(posedge clk) disable iff (rst)
        (mode_q != RLD_IMMED && !(tick && (zero || period))) |=> $stable(active_q)); // R9

endmodule

// File: rtl/aq_channel.sv
module aq_channel
    import pwm_aq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             act_we,
    input  logic [ACT_W-1:0] act_wdata,
    input  logic             tick,
    input  tb_events_t       ev,
    input  logic [1:0]       frc,
    output logic             out
);

    logic [ACT_W-1:0] act_q;
    logic             out_q;
    act_e             chosen;
    logic             nxt;

    // lowest priority first; later assignments win
    always_comb begin
        chosen = ACT_NONE;
        if (ev.zero   && act_field(act_q, OFS_ZERO) != ACT_NONE) chosen = act_field(act_q, OFS_ZERO);
        if (ev.period && act_field(act_q, OFS_PRD)  != ACT_NONE) chosen = act_field(act_q, OFS_PRD);
        if (ev.cmp_b  && act_field(act_q, OFS_CMPB) != ACT_NONE) chosen = act_field(act_q, OFS_CMPB);
        if (ev.cmp_a  && act_field(act_q, OFS_CMPA) != ACT_NONE) chosen = act_field(act_q, OFS_CMPA);
    end

    always_comb begin
        case (frc)
            2'b01:   nxt = 1'b0;
            2'b10:   nxt = 1'b1;
            default: nxt = apply_act(out_q, chosen);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            out_q <= 1'b0;
        end else begin
            if (act_we) act_q <= act_wdata;
            if (tick)   out_q <= nxt;
        end
    end

    assign out = out_q;

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !out_q); // R1

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(out_q)); // R6

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
        (tick && frc == 2'b01) |=> !out_q); // R7

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (tick && frc == 2'b10) |=> out_q); // R7

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] tb_count,
    input  logic             tb_zero,
    input  logic             tb_period,
    input  logic             tb_up,
    input  logic             cmp_a_we,
    input  logic             cmp_b_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             act_a_we,
    input  logic             act_b_we,
    input  logic [ACT_W-1:0] act_wdata,
    input  logic             frc_we,
    input  logic [FRC_W-1:0] frc_wdata,
    input  logic             rld_we,
    input  logic [1:0]       rld_wdata,
    output logic             pwm_a,
    output logic             pwm_b
);

    logic [N_CH-1:0]  cmp_we_v;
    logic [N_CH-1:0]  act_we_v;
    logic [N_CH-1:0]  match_v;
    logic [N_CH-1:0]  out_v;
    logic [FRC_W-1:0] frc_active;
    tb_events_t       ev;

    assign cmp_we_v = {cmp_b_we, cmp_a_we};
    assign act_we_v = {act_b_we, act_a_we};

    assign ev.zero   = tick & tb_zero;
    assign ev.period = tick & tb_period;
    assign ev.cmp_a  = match_v[0];
    assign ev.cmp_b  = match_v[1];

    aq_force u_force (
        .clk        (clk),
        .rst        (rst),
        .we         (frc_we),
        .wdata      (frc_wdata),
        .mode_we    (rld_we),
        .mode_wdata (rld_wdata),
        .tick       (tick),
        .zero       (tb_zero),
        .period     (tb_period),
        .active     (frc_active)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        aq_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk   (clk),
            .rst   (rst),
            .we    (cmp_we_v[ch]),
            .wdata (cmp_wdata),
            .tick  (tick),
            .up    (tb_up),
            .count (tb_count),
            .match (match_v[ch])
        );

        aq_channel u_chan (
            .clk       (clk),
            .rst       (rst),
            .act_we    (act_we_v[ch]),
            .act_wdata (act_wdata),
            .tick      (tick),
            .ev        (ev),
            .frc       (frc_active[2*ch +: 2]),
            .out       (out_v[ch])
        );
    end

    assign pwm_a = out_v[0];
    assign pwm_b = out_v[1];

endmodule

// File: tb/pwm_action_qual_test.sv
module pwm_action_qual_test;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [CW-1:0] tb_count = '0;
    logic          tb_zero = 1'b0, tb_period = 1'b0, tb_up = 1'b1;
    logic          cmp_a_we = 1'b0, cmp_b_we = 1'b0;
    logic [CW-1:0] cmp_wdata = '0;
    logic          act_a_we = 1'b0, act_b_we = 1'b0;
    logic [9:0]    act_wdata = '0;
    logic          frc_we = 1'b0;
    logic [3:0]    frc_wdata = '0;
    logic          rld_we = 1'b0;
    logic [1:0]    rld_wdata = '0;
    logic          pwm_a, pwm_b;

    always #5 clk = ~clk;

    pwm_action_qual #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .tick(tick), .tb_count(tb_count),
        .tb_zero(tb_zero), .tb_period(tb_period), .tb_up(tb_up),
        .cmp_a_we(cmp_a_we), .cmp_b_we(cmp_b_we), .cmp_wdata(cmp_wdata),
        .act_a_we(act_a_we), .act_b_we(act_b_we), .act_wdata(act_wdata),
        .frc_we(frc_we), .frc_wdata(frc_wdata),
        .rld_we(rld_we), .rld_wdata(rld_wdata),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    int    checks = 0;
    int    errors = 0;
    string req = "R1";

    // reference state
    logic          m_out [2];
    logic [9:0]    m_act [2];
    logic [CW-1:0] m_cmp [2];
    logic [3:0]    m_fsh = '0, m_fac = '0;
    logic [1:0]    m_mode = '0;

    // time base generator
    int tb_c = 0;
    int tb_p = 9;
    bit dir_up = 1'b1;
    bit updown = 1'b0;
    int tick_div = 1;
    int tick_ph = 0;

    function automatic logic apply_code(logic cur, logic [1:0] c);
        if (c == 2'd1) return 1'b0;
        if (c == 2'd2) return 1'b1;
        if (c == 2'd3) return !cur;
        return cur;
    endfunction

    task automatic check(string r, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", r, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic       n_out [2];
        logic [3:0] n_fac;
        logic [1:0] f, code;
        bit         ca, cb, reload;
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_out[c] = 1'b0; m_act[c] = '0; m_cmp[c] = '0;
            end
            m_fsh = '0; m_fac = '0; m_mode = '0;
            return;
        end
        ca = tick && tb_up && (tb_count == m_cmp[0]);
        cb = tick && tb_up && (tb_count == m_cmp[1]);
        for (int c = 0; c < 2; c++) begin
            n_out[c] = m_out[c];
            if (tick) begin
                f = m_fac[2*c +: 2];
                if (f == 2'd1)      n_out[c] = 1'b0;
                else if (f == 2'd2) n_out[c] = 1'b1;
                else begin
                    code = 2'd0;
                    if (ca && m_act[c][5:4] != 0)             code = m_act[c][5:4];
                    else if (cb && m_act[c][9:8] != 0)        code = m_act[c][9:8];
                    else if (tb_period && m_act[c][3:2] != 0) code = m_act[c][3:2];
                    else if (tb_zero && m_act[c][1:0] != 0)   code = m_act[c][1:0];
                    n_out[c] = apply_code(m_out[c], code);
                end
            end
        end
        n_fac = m_fac;
        if (m_mode == 2'd3) n_fac = frc_we ? frc_wdata : m_fsh;
        else begin
            reload = tick && ((m_mode == 2'd0 && tb_zero) ||
                              (m_mode == 2'd1 && tb_period) ||
                              (m_mode == 2'd2 && (tb_zero || tb_period)));
            if (reload) n_fac = m_fsh;
        end
        if (frc_we)   m_fsh = frc_wdata;
        if (rld_we)   m_mode = rld_wdata;
        if (act_a_we) m_act[0] = act_wdata;
        if (act_b_we) m_act[1] = act_wdata;
        if (cmp_a_we) m_cmp[0] = cmp_wdata;
        if (cmp_b_we) m_cmp[1] = cmp_wdata;
        m_fac = n_fac;
        m_out[0] = n_out[0];
        m_out[1] = n_out[1];
    endtask

    // one clock: drive time base, predict, pass the edge, compare
    task automatic cyc();
        tick      = (tick_ph == 0);
        tb_count  = CW'(tb_c);
        tb_zero   = (tb_c == 0);
        tb_period = (tb_c == tb_p);
        tb_up     = dir_up;
        model_step();
        @(negedge clk);
        check(req, pwm_a, m_out[0], "pwm_a");
        check(req, pwm_b, m_out[1], "pwm_b");
        if (tick && !rst) begin
            if (!updown) begin
                dir_up = 1'b1;
                tb_c = (tb_c == tb_p) ? 0 : tb_c + 1;
            end else if (dir_up) begin
                if (tb_c == tb_p) begin dir_up = 1'b0; tb_c = tb_c - 1; end
                else tb_c = tb_c + 1;
            end else begin
                if (tb_c == 0) begin dir_up = 1'b1; tb_c = tb_c + 1; end
                else tb_c = tb_c - 1;
            end
        end
        tick_ph = (tick_ph + 1) % tick_div;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_cmp(int ch, int v);
        cmp_wdata = CW'(v);
        if (ch == 0) cmp_a_we = 1'b1; else cmp_b_we = 1'b1;
        cyc();
        cmp_a_we = 1'b0; cmp_b_we = 1'b0;
    endtask

    task automatic wr_act(int ch, logic [9:0] v);
        act_wdata = v;
        if (ch == 0) act_a_we = 1'b1; else act_b_we = 1'b1;
        cyc();
        act_a_we = 1'b0; act_b_we = 1'b0;
    endtask

    task automatic wr_frc(logic [3:0] v);
        frc_wdata = v; frc_we = 1'b1;
        cyc();
        frc_we = 1'b0;
    endtask

    task automatic wr_mode(logic [1:0] v);
        rld_wdata = v; rld_we = 1'b1;
        cyc();
        rld_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state and idle outputs with all fields at 00
        req = "R1";
        rst = 1'b1;
        run(3);
        check("R1", pwm_a, 1'b0, "reset pwm_a");
        check("R1", pwm_b, 1'b0, "reset pwm_b");
        rst = 1'b0;
        run(24);

        // R2: normal polarity, high at zero/period, low on compare-up
        req = "R2";
        wr_cmp(0, 3);
        wr_cmp(1, 6);
        wr_act(0, 10'h01A);
        wr_act(1, 10'h10A);
        run(30);
        // R2: toggle on period
        wr_act(0, 10'h00C);
        run(25);
        // R2: inverted polarity
        wr_act(0, 10'h025);
        run(25);

        // R3: output A reacting to compare-B field in bits 9:8
        req = "R3";
        wr_act(0, 10'h201);
        run(25);
        // R3: bits 7:6 carry no event
        wr_act(0, 10'h0C2);
        run(25);

        // R5: compare-A-up coinciding with zero
        req = "R5";
        wr_cmp(0, 0);
        wr_act(0, 10'h012);
        run(25);
        // R5: compare-B-up coinciding with period
        wr_cmp(1, 9);
        wr_act(1, 10'h10A);
        run(25);
        // R5: compare A over compare B
        wr_cmp(0, 4);
        wr_cmp(1, 4);
        wr_act(0, 10'h212);
        run(25);
        // R5: a 00 compare code falls through to the zero code
        wr_cmp(0, 0);
        wr_act(0, 10'h00E);
        run(25);

        // R4: up-down counting, compare toggles only while counting up
        req = "R4";
        updown = 1'b1;
        wr_cmp(0, 5);
        wr_act(0, 10'h030);
        wr_act(1, 10'h300);
        wr_cmp(1, 0);
        run(45);

        // R6: outputs move only on ticks
        req = "R6";
        updown = 1'b0;
        wr_cmp(0, 3);
        wr_cmp(1, 6);
        wr_act(0, 10'h01A);
        wr_act(1, 10'h10A);
        tick_div = 3;
        run(60);
        tick_div = 1;
        tick_ph = 0;

        // R7: immediate force, A low B high, then swapped, then released
        req = "R7";
        wr_mode(2'd3);
        wr_frc(4'b1001);
        run(20);
        check("R7", pwm_a, 1'b0, "forced low A");
        check("R7", pwm_b, 1'b1, "forced high B");
        wr_frc(4'b0110);
        run(20);
        check("R7", pwm_a, 1'b1, "forced high A");
        check("R7", pwm_b, 1'b0, "forced low B");
        wr_frc(4'b1111);
        run(25);

        // R8: reload at zero, at period, at either
        req = "R8";
        wr_mode(2'd0);
        wr_frc(4'b0001);
        run(25);
        wr_mode(2'd1);
        wr_frc(4'b1000);
        run(25);
        wr_mode(2'd2);
        wr_frc(4'b0000);
        run(25);
        wr_frc(4'b0110);
        run(12);

        // R9: shadow write away from reload point leaves outputs on events
        req = "R9";
        wr_mode(2'd0);
        wr_frc(4'b0000);
        run(15);
        while (tb_c != 2) cyc();
        wr_frc(4'b1010);
        run(4);
        wr_frc(4'b0101);
        run(20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule